// File: doc/BRIEF.md
# Serial ADC Output Interface Emulator

This block stands in for the digital serial side of a 12-bit successive-approximation converter. A stub source supplies a parallel sample word. The block takes in three interface signals: an active-low chip select, a serial clock and a serial data output. It decides when the sample is taken and shifts the conversion frame out bit by bit. It also recognises a power-down request from the point at which a host ends a frame early. Three status flags report the current mode: tracking, converting or powered down. A further flag marks whether the data of the latest frame can be used.

The block runs on a system clock. Chip select and the serial clock are treated as levels that are synchronous to that clock. Their edges are found by comparing each level with its value one system clock earlier. The serial clock must stay at each level for at least two system clocks and idles high between frames. Every output responds on the system clock edge that first sees the new input level. When chip select is high the data output is logically undriven, shown by a low output enable.

Top module: `adc_serial_emu`

## Requirements
- R1: The sample word is captured on the system clock edge that first sees chip select low. The data bits of that same frame carry this word, with no pipeline delay, and later changes of the parallel input have no effect on the frame.
- R2: The frame is sent as two zeros, then the 12 data bits from most to least significant, then two zeros. Frame bit 0 appears on the edge that detects the chip select fall. Frame bit n appears on the edge that detects the n-th falling serial clock edge, and frame positions beyond 15 are 0.
- R3: While a frame is open, the data output changes only at a detected falling serial clock edge or at the chip select fall. A rising serial clock edge leaves it unchanged.
- R4: Output enable goes high on the edge that detects the chip select fall and low on the edge that detects the chip select rise.
- R5: A chip select fall puts the block into convert mode. The mode flags are encoded as {powerdown, convert, track} = 3'b010.
- R6: The 14th rising serial clock edge of a frame returns the block to track mode (3'b001) while chip select is still low.
- R7: If chip select rises once 2 to 9 falling serial clock edges have been seen in the frame, the block enters power-down (3'b100). It stays there until the next chip select fall.
- R8: If chip select rises with fewer than 2 or more than 9 falling edges seen, the block ends in track mode. This includes a frame cut short after 14 clocks, which omits the trailing zeros.
- R9: The frame-valid flag is low during a frame that starts from power-down (the wake-up frame). It is high during a frame that starts from track mode.
- R10: Exactly one mode flag is high at all times. After reset the block is in track mode, with output enable low, data low and frame-valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| sample_in | input | 12 | Parallel sample word from the stub source |
| sdata | output | 1 | Serial data output |
| sdata_oe | output | 1 | Output enable for sdata; low means undriven |
| st_track | output | 1 | Track mode flag |
| st_convert | output | 1 | Convert mode flag |
| st_powerdown | output | 1 | Power-down flag |
| frame_valid | output | 1 | Data of the current frame is valid |

## Verification
Full 16-clock frames are sent with all-ones, all-zeros, alternating and end-bit patterns. These show whether the bit order and the zero padding are right and whether any data bit is stuck or swapped. The parallel input is inverted right after each chip select fall, which separates a capture at the sampling instant from a late or continuous capture. Frames are cut after 0, 1, 2, 9, 10 and 14 clocks to probe both edges of the power-down window and the shortened frame. Each power-down is followed by a wake-up frame and then a normal frame, to confirm when the valid flag drops and when it recovers.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

  typedef enum logic [1:0] {
    MODE_TRACK   = 2'd0,
    MODE_CONVERT = 2'd1,
    MODE_PDOWN   = 2'd2
  } adc_mode_e;

  localparam int DEF_DATA_W     = 12;
  localparam int DEF_LEAD_ZEROS = 2;
  localparam int DEF_TRAIL_ZEROS = 2;
  localparam int DEF_TRACK_RISE = 14;
  localparam int DEF_PD_FIRST   = 2;
  localparam int DEF_PD_LAST    = 10;

endpackage

// File: rtl/adc_serial_edges.sv
module adc_serial_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_fall,
  output logic sck_rise
);
  logic cs_q;
  logic sck_q;
  logic in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b1;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sclk;
    end
  end

  // serial clock edges only count while chip select stays low
  assign in_frame = !cs_q && !cs_n;
  assign cs_fall  = cs_q && !cs_n;
  assign cs_rise  = !cs_q && cs_n;
  assign sck_fall = in_frame && sck_q && !sclk;
  assign sck_rise = in_frame && !sck_q && sclk;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_serial_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int TRACK_RISE = DEF_TRACK_RISE,
  parameter int PD_FIRST   = DEF_PD_FIRST,
  parameter int PD_LAST    = DEF_PD_LAST,
  parameter int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_fall,
  input  logic             sck_rise,
  output logic [CNT_W-1:0] fall_cnt,
  output adc_mode_e        mode,
  output logic             frame_valid,
  output logic             pd_abort
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] rise_cnt;

  function automatic logic in_pd_window(input logic [CNT_W-1:0] n);
    return (int'(n) >= PD_FIRST) && (int'(n) < PD_LAST);
  endfunction

  function automatic logic ends_conversion(input logic [CNT_W-1:0] n);
    return (int'(n) + 1) == TRACK_RISE;
  endfunction

  assign pd_abort = cs_rise && in_pd_window(fall_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt    <= '0;
      rise_cnt    <= '0;
      mode        <= MODE_TRACK;
      frame_valid <= 1'b0;
    end else if (cs_fall) begin
      fall_cnt    <= '0;
      rise_cnt    <= '0;
      mode        <= MODE_CONVERT;
      frame_valid <= (mode != MODE_PDOWN);
    end else if (cs_rise) begin
      mode <= pd_abort ? MODE_PDOWN : MODE_TRACK;
    end else begin
      if (sck_fall && fall_cnt != CNT_MAX) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
      if (sck_rise) begin
        if (rise_cnt != CNT_MAX) begin
          rise_cnt <= rise_cnt + 1'b1;
        end
        if (ends_conversion(rise_cnt)) begin
          mode <= MODE_TRACK;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 2,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_fall,
  input  logic [CNT_W-1:0]  fall_cnt,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata,
  output logic              sdata_oe
);
  logic [DATA_W-1:0] word_q;

  // bit of the frame at position pos: zero padding outside the data field
  function automatic logic frame_bit(input logic [DATA_W-1:0] w, input int pos);
    logic [DATA_W-1:0] t;
    if (pos < LEAD_ZEROS || pos >= LEAD_ZEROS + DATA_W) begin
      return 1'b0;
    end
    t = w << (pos - LEAD_ZEROS);
    return t[DATA_W-1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else if (cs_fall) begin
      word_q   <= sample_in;
      sdata    <= frame_bit(sample_in, 0);
      sdata_oe <= 1'b1;
    end else if (cs_rise) begin
      sdata_oe <= 1'b0;
    end else if (sck_fall) begin
      sdata <= frame_bit(word_q, int'(fall_cnt) + 1);
    end
  end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_serial_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int LEAD_ZEROS  = DEF_LEAD_ZEROS,
  parameter int TRAIL_ZEROS = DEF_TRAIL_ZEROS,
  parameter int TRACK_RISE  = DEF_TRACK_RISE,
  parameter int PD_FIRST    = DEF_PD_FIRST,
  parameter int PD_LAST     = DEF_PD_LAST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              st_track,
  output logic              st_convert,
  output logic              st_powerdown,
  output logic              frame_valid
);
  localparam int FRAME_LEN = LEAD_ZEROS + DATA_W + TRAIL_ZEROS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  // named internal events, also used by the bound checker
  logic             cs_fall;
  logic             cs_rise;
  logic             sck_fall;
  logic             sck_rise;
  logic             pd_abort;
  logic [CNT_W-1:0] fall_cnt;
  adc_mode_e        mode;

  adc_serial_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_fall (sck_fall),
    .sck_rise (sck_rise)
  );

  adc_serial_seq #(
    .FRAME_LEN  (FRAME_LEN),
    .TRACK_RISE (TRACK_RISE),
    .PD_FIRST   (PD_FIRST),
    .PD_LAST    (PD_LAST),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .sck_fall    (sck_fall),
    .sck_rise    (sck_rise),
    .fall_cnt    (fall_cnt),
    .mode        (mode),
    .frame_valid (frame_valid),
    .pd_abort    (pd_abort)
  );

  adc_serial_shifter #(
    .DATA_W     (DATA_W),
    .LEAD_ZEROS (LEAD_ZEROS),
    .CNT_W      (CNT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sck_fall  (sck_fall),
    .fall_cnt  (fall_cnt),
    .sample_in (sample_in),
    .sdata     (sdata),
    .sdata_oe  (sdata_oe)
  );

  assign st_track     = (mode == MODE_TRACK);
  assign st_convert   = (mode == MODE_CONVERT);
  assign st_powerdown = (mode == MODE_PDOWN);
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sck_fall,
  input logic             pd_abort,
  input logic [CNT_W-1:0] fall_cnt,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             st_track,
  input logic             st_convert,
  input logic             st_powerdown,
  input logic             frame_valid
);
  // R5
  enter_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> st_convert);

  // R2
  first_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !sdata);

  // R2
  second_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && fall_cnt == '0) |=> !sdata);

  // R3
  data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(sdata));

  // R4
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdata_oe);

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdata_oe);

  // R7
  abort_to_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_abort |=> st_powerdown);

  // R7
  pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_powerdown && !cs_fall) |=> st_powerdown);

  // R8
  plain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !pd_abort) |=> st_track);

  // R9
  wake_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && st_powerdown) |=> !frame_valid);

  // R9
  normal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && st_track) |=> frame_valid);

  // R10
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_track, st_convert, st_powerdown}) == 1);
endmodule

bind adc_serial_emu adc_serial_emu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_fall      (cs_fall),
  .cs_rise      (cs_rise),
  .sck_fall     (sck_fall),
  .pd_abort     (pd_abort),
  .fall_cnt     (fall_cnt),
  .sdata        (sdata),
  .sdata_oe     (sdata_oe),
  .st_track     (st_track),
  .st_convert   (st_convert),
  .st_powerdown (st_powerdown),
  .frame_valid  (frame_valid)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample_in = '0;
  logic        sdata, sdata_oe, st_track, st_convert, st_powerdown, frame_valid;

  adc_serial_emu uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
    .sdata(sdata), .sdata_oe(sdata_oe), .st_track(st_track), .st_convert(st_convert),
    .st_powerdown(st_powerdown), .frame_valid(frame_valid)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    int         kind;   // 0 sdata, 1 oe, 2 mode {pd,conv,track}, 3 valid
    logic [2:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    bm_pd = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int kind, input logic [2:0] exp, input string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compares items that fall due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic [2:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {2'b00, sdata};
        1:       act = {2'b00, sdata_oe};
        2:       act = {st_powerdown, st_convert, st_track};
        default: act = {2'b00, frame_valid};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind %0d at cycle %0d: actual %b expected %b",
                 it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  function automatic logic exp_bit(input logic [11:0] s, input int pos);
    if (pos >= 2 && pos <= 13) return s[13 - pos];
    return 1'b0;
  endfunction

  // one frame: chip select low, k serial clock periods, chip select high
  task automatic frame(input logic [11:0] s, input int k);
    logic       b;
    logic       pd;
    logic [2:0] end_mode;
    string      end_tag;
    @(negedge clk);
    sample_in = s; cs_n = 1'b0;
    push(0, 3'b000, "R2"); push(1, 3'b001, "R4");
    push(2, 3'b010, "R5"); push(3, {2'b00, !bm_pd}, "R9");
    @(negedge clk);
    sample_in = ~s;   // later input changes must not reach the frame (R1)
    for (int i = 1; i <= k; i++) begin
      b = exp_bit(s, i);
      @(negedge clk); sclk = 1'b0;
      push(0, {2'b00, b}, (i >= 2 && i <= 13) ? "R1/R2" : "R2");
      @(negedge clk);
      push(0, {2'b00, b}, "R3");
      @(negedge clk); sclk = 1'b1;
      push(0, {2'b00, b}, "R3");
      if (i >= 14) push(2, 3'b001, "R6");
      else         push(2, 3'b010, "R5");
      @(negedge clk);
    end
    pd       = (k >= 2 && k <= 9);
    end_mode = pd ? 3'b100 : 3'b001;
    end_tag  = pd ? "R7" : "R8";
    @(negedge clk); cs_n = 1'b1;
    push(1, 3'b000, "R4"); push(2, end_mode, end_tag);
    @(negedge clk); @(negedge clk);
    push(2, end_mode, end_tag);
    push(2, end_mode, "R10");
    bm_pd = pd;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(2, 3'b001, "R10"); push(1, 3'b000, "R10");
    push(0, 3'b000, "R10"); push(3, 3'b000, "R10");
    @(negedge clk);
    // full frames with distinct patterns
    frame(12'hFFF, 16);
    frame(12'h000, 16);
    frame(12'hA5C, 16);
    frame(12'h801, 16);
    // shortened frame, then power-down windows and wake-ups
    frame(12'h3C7, 14);
    frame(12'h5A3, 5);
    frame(12'h6B1, 16);   // wake-up frame, invalid (R9)
    frame(12'h0F0, 16);   // valid again (R9)
    frame(12'h111, 0);
    frame(12'h222, 1);
    frame(12'h333, 2);
    frame(12'h444, 16);
    frame(12'h555, 10);
    frame(12'h666, 9);
    frame(12'h777, 14);
    frame(12'h888, 16);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule